// File: doc/BRIEF.md
# SD Card Command and Data Register Bridge

A word-addressed register bridge between a 32-bit host bus and the command and data paths of a memory card. The host writes a card command one byte at a time into a single command register. Once six bytes have been collected, the block presents the command index, the 32-bit argument and the check byte on a card-side valid/ready port. It stores the response the card returns with its own framing, and the host then reads it back one byte per read of the same register.

A data register turns each host word into four bytes toward the card, sending the most significant byte first. When the host reads it, the block gathers four bytes from the card into one word. A card-present input gates both paths. Three control registers (clock divider, enable, start) are simple storage, and a pending register mirrors the receive enables. An access stalls (no acknowledge) only while the block waits on the card.

Top module: `sd_cmd_bridge`

## Requirements
- R1: After reset the clock-divider, enable, pending and start registers read 0 and the response length is 0. The first command-register read returns 0x00 and raises `rsp_wrap_o`.
- R2: The clock divider (byte address 0x00), enable (0x04) and start (0x0C) registers store and read back all 32 bits. `clkdiv_o`, `enable_o` (bits 3:0) and `start_o` (bits 1:0) show the stored values.
- R3: Any write to the enable or pending register (0x08) reloads pending with bit1 = enable bit1 and bit3 = enable bit3, and all other bits 0. A write to pending therefore cannot clear a bit whose enable is set.
- R4: Command-register writes (0x10) store the low byte. The sixth write issues a request with index = byte0 & 0x3F, argument = bytes 1..4 (byte1 most significant) and check byte = byte5. `cmd_valid_o` and the request fields hold until `cmd_ready_i`.
- R5: A 16-byte response (`rsp_len_i`=16) reads back as 0x3F followed by the 16 card bytes in order (byte 0 at `rsp_data_i[127:120]`). The readable length is 17.
- R6: A 4-byte response reads back as the command index, the 4 card bytes, then 0x00. The readable length is 6.
- R7: A command read at pointer p returns buffer byte p. If p+1 exceeds the response length, the pointer returns to 0 and `rsp_wrap_o` is high in that acknowledge cycle. Otherwise the pointer advances by one.
- R8: After a request with index 0, the next command-register write is acknowledged but discarded. Writes after it are collected normally.
- R9: While a request is outstanding on the card port, reads and writes of the command register are not acknowledged.
- R10: A data write (0x14) sends the four bytes of the word on the transmit byte port, bits 31:24 first.
- R11: A data read collects four bytes from the receive byte port, the first into bits 31:24, and is acknowledged once the fourth has arrived.
- R12: With `card_present_i` low, command and data writes are acknowledged with no effect. Command reads return 0x000000FF and data reads return 0xFFFFFFFF.
- R13: An access to word offsets 6 and 7, or to an address with bits 1:0 nonzero, reads 0 and writes nothing. It is acknowledged at once with `bus_unmap_o` high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Host access request, held until acknowledged |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | Access completes this cycle |
| bus_unmap_o | output | 1 | Unmapped or misaligned access strobe |
| rsp_wrap_o | output | 1 | Response read ran past the length |
| card_present_i | input | 1 | Card inserted |
| clkdiv_o | output | 32 | Clock divider register |
| enable_o | output | 4 | Enable register bits 3:0 |
| start_o | output | 2 | Start register bits 1:0 |
| cmd_valid_o | output | 1 | Request valid |
| cmd_ready_i | input | 1 | Card accepts request, response fields valid |
| cmd_index_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_crc_o | output | 8 | Command check byte |
| rsp_len_i | input | 5 | Response byte count (0, 4 or 16) |
| rsp_data_i | input | 128 | Response bytes, first in bits 127:120 |
| dat_tx_valid_o | output | 1 | Transmit byte valid |
| dat_tx_ready_i | input | 1 | Card takes transmit byte |
| dat_tx_byte_o | output | 8 | Transmit byte |
| dat_rx_valid_i | input | 1 | Receive byte valid |
| dat_rx_ready_o | output | 1 | Block takes receive byte |
| dat_rx_byte_i | input | 8 | Receive byte |

## Verification
The bench walks both response framings through to the read that runs past the end. A wrong length makes the wrap strobe fire early or late, and a wrong pad shows up as a stray byte. It issues a command with index 0 and then seven more writes. A design that drops nothing (or too much) reports a different index or argument on the card port. It also writes the command register while the card is absent and then sends a full command. Any byte stored while absent would shift the next request's index. Pending writes are checked against the enables, and byte order is checked in both data directions.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CMD_BYTES = 6;
  localparam int unsigned RSP_LONG  = 16;
  localparam int unsigned RSP_SHORT = 4;
  localparam int unsigned RSP_BUF   = RSP_LONG + 1;
  localparam int unsigned NUM_REGS  = 6;
  localparam logic [BYTE_W-1:0] LONG_TAG = 8'h3F;

  typedef enum logic [2:0] {
    OFF_CLKDIV  = 3'd0,
    OFF_ENABLE  = 3'd1,
    OFF_PENDING = 3'd2,
    OFF_START   = 3'd3,
    OFF_CMD     = 3'd4,
    OFF_DAT     = 3'd5
  } reg_off_e;
endpackage

// File: rtl/sdb_regs.sv
module sdb_regs
  import sdb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_clkdiv_i,
  input  logic              wr_enable_i,
  input  logic              wr_pending_i,
  input  logic              wr_start_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] clkdiv_o,
  output logic [WORD_W-1:0] enable_o,
  output logic [WORD_W-1:0] pending_o,
  output logic [WORD_W-1:0] start_o
);
  function automatic logic [WORD_W-1:0] rx_mirror(input logic [WORD_W-1:0] en);
    logic [WORD_W-1:0] p;
    p    = '0;
    p[1] = en[1];
    p[3] = en[3];
    return p;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clkdiv_o  <= '0;
      enable_o  <= '0;
      pending_o <= '0;
      start_o   <= '0;
    end else begin
      if (wr_clkdiv_i) clkdiv_o <= wdata_i;
      if (wr_start_i)  start_o  <= wdata_i;
      if (wr_enable_i) begin
        enable_o  <= wdata_i;
        pending_o <= rx_mirror(wdata_i);
      end else if (wr_pending_i) begin
        pending_o <= rx_mirror(enable_o);
      end
    end
  end

  p_pending_tx_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o[0] == 1'b0 && pending_o[2] == 1'b0);
  p_pending_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_enable_i |=> pending_o[1] == enable_o[1] && pending_o[3] == enable_o[3]);
endmodule

// File: rtl/sdb_cmd.sv
module sdb_cmd
  import sdb_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  logic [BYTE_W-1:0]          wbyte_i,
  output logic                       busy_o,
  output logic [BYTE_W-1:0]          rbyte_o,
  output logic                       wrap_o,
  output logic                       cmd_valid_o,
  input  logic                       cmd_ready_i,
  output logic [5:0]                 cmd_index_o,
  output logic [WORD_W-1:0]          cmd_arg_o,
  output logic [BYTE_W-1:0]          cmd_crc_o,
  input  logic [4:0]                 rsp_len_i,
  input  logic [RSP_LONG*BYTE_W-1:0] rsp_data_i
);
  localparam int unsigned WP_W = $clog2(CMD_BYTES);
  localparam int unsigned RP_W = $clog2(RSP_BUF + 1);

  logic [WP_W-1:0]   wr_ptr_q;
  logic [RP_W-1:0]   rd_ptr_q, len_q;
  logic [5:0]        idx_acc_q;
  logic [WORD_W-1:0] arg_acc_q;
  logic              drop_q;
  logic [BYTE_W-1:0] rsp_q [RSP_BUF];

  assign cmd_valid_o = busy_o;
  assign rbyte_o     = (rd_ptr_q < RP_W'(RSP_BUF)) ? rsp_q[rd_ptr_q] : '0;
  assign wrap_o      = rd_i && ((rd_ptr_q + RP_W'(1)) > len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      len_q       <= '0;
      idx_acc_q   <= '0;
      arg_acc_q   <= '0;
      drop_q      <= 1'b0;
      busy_o      <= 1'b0;
      cmd_index_o <= '0;
      cmd_arg_o   <= '0;
      cmd_crc_o   <= '0;
      for (int k = 0; k < RSP_BUF; k++) rsp_q[k] <= '0;
    end else begin
      if (busy_o && cmd_ready_i) begin
        busy_o   <= 1'b0;
        drop_q   <= (cmd_index_o == 6'd0);
        rd_ptr_q <= '0;
        rsp_q[0] <= {2'b00, cmd_index_o};
        for (int k = 0; k < RSP_LONG; k++)
          rsp_q[k+1] <= rsp_data_i[(RSP_LONG-1-k)*BYTE_W +: BYTE_W];
        if (rsp_len_i == 5'(RSP_LONG)) begin
          rsp_q[0] <= LONG_TAG;
          len_q    <= RP_W'(RSP_LONG + 1);
        end else if (rsp_len_i == 5'(RSP_SHORT)) begin
          rsp_q[RSP_SHORT+1] <= '0;
          len_q              <= RP_W'(RSP_SHORT + 2);
        end else begin
          len_q <= RP_W'(rsp_len_i);
        end
      end
      if (wr_i) begin
        if (drop_q) begin
          drop_q <= 1'b0;
        end else if (wr_ptr_q == WP_W'(CMD_BYTES - 1)) begin
          wr_ptr_q    <= '0;
          busy_o      <= 1'b1;
          cmd_index_o <= idx_acc_q;
          cmd_arg_o   <= arg_acc_q;
          cmd_crc_o   <= wbyte_i;
        end else begin
          if (wr_ptr_q == '0) idx_acc_q <= wbyte_i[5:0];
          else arg_acc_q[(4 - int'(wr_ptr_q))*BYTE_W +: BYTE_W] <= wbyte_i;
          wr_ptr_q <= wr_ptr_q + WP_W'(1);
        end
      end
      if (rd_i) rd_ptr_q <= wrap_o ? '0 : rd_ptr_q + RP_W'(1);
    end
  end

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_index_o) &&
    $stable(cmd_arg_o) && $stable(cmd_crc_o));
  p_no_access_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !wr_i && !rd_i);
  p_wrap_to_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> rd_ptr_q == '0);
  p_rd_ptr_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ptr_q <= RP_W'(RSP_BUF) && wr_ptr_q < WP_W'(CMD_BYTES));
  p_drop_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q && wr_i |=> !drop_q && !busy_o);
endmodule

// File: rtl/sdb_dat.sv
module sdb_dat
  import sdb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_req_i,
  output logic              tx_busy_o,
  output logic              rx_full_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              dat_tx_valid_o,
  input  logic              dat_tx_ready_i,
  output logic [BYTE_W-1:0] dat_tx_byte_o,
  input  logic              dat_rx_valid_i,
  output logic              dat_rx_ready_o,
  input  logic [BYTE_W-1:0] dat_rx_byte_i
);
  localparam int unsigned BPW   = WORD_W / BYTE_W;
  localparam int unsigned CNT_W = $clog2(BPW);

  logic [WORD_W-1:0] tx_sh_q;
  logic [CNT_W-1:0]  tx_cnt_q, rx_cnt_q;

  assign dat_tx_valid_o = tx_busy_o;
  assign dat_tx_byte_o  = tx_sh_q[WORD_W-1 -: BYTE_W];
  assign dat_rx_ready_o = rd_req_i && !rx_full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q   <= '0;
      tx_cnt_q  <= '0;
      tx_busy_o <= 1'b0;
      rx_cnt_q  <= '0;
      rx_full_o <= 1'b0;
      rd_word_o <= '0;
    end else begin
      if (wr_i) begin
        tx_sh_q   <= wdata_i;
        tx_cnt_q  <= '0;
        tx_busy_o <= 1'b1;
      end else if (tx_busy_o && dat_tx_ready_i) begin
        tx_sh_q  <= tx_sh_q << BYTE_W;
        tx_cnt_q <= tx_cnt_q + CNT_W'(1);
        if (tx_cnt_q == CNT_W'(BPW - 1)) tx_busy_o <= 1'b0;
      end
      if (rd_req_i && rx_full_o) begin
        rx_full_o <= 1'b0;
      end else if (dat_rx_ready_o && dat_rx_valid_i) begin
        rd_word_o <= {rd_word_o[WORD_W-BYTE_W-1:0], dat_rx_byte_i};
        rx_cnt_q  <= rx_cnt_q + CNT_W'(1);
        if (rx_cnt_q == CNT_W'(BPW - 1)) rx_full_o <= 1'b1;
      end
    end
  end

  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_tx_valid_o && !dat_tx_ready_i |=> dat_tx_valid_o && $stable(dat_tx_byte_o));
  p_rx_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o && !rd_req_i |=> rx_full_o && $stable(rd_word_o));
endmodule

// File: rtl/sd_cmd_bridge.sv
module sd_cmd_bridge
  import sdb_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_req_i,
  input  logic                       bus_we_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [31:0]                bus_wdata_i,
  output logic [31:0]                bus_rdata_o,
  output logic                       bus_ack_o,
  output logic                       bus_unmap_o,
  output logic                       rsp_wrap_o,
  input  logic                       card_present_i,
  output logic [31:0]                clkdiv_o,
  output logic [3:0]                 enable_o,
  output logic [1:0]                 start_o,
  output logic                       cmd_valid_o,
  input  logic                       cmd_ready_i,
  output logic [5:0]                 cmd_index_o,
  output logic [31:0]                cmd_arg_o,
  output logic [7:0]                 cmd_crc_o,
  input  logic [4:0]                 rsp_len_i,
  input  logic [127:0]               rsp_data_i,
  output logic                       dat_tx_valid_o,
  input  logic                       dat_tx_ready_i,
  output logic [7:0]                 dat_tx_byte_o,
  input  logic                       dat_rx_valid_i,
  output logic                       dat_rx_ready_o,
  input  logic [7:0]                 dat_rx_byte_i
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic mapped, sel_clk, sel_en, sel_pend, sel_start, sel_cmd, sel_dat;
  logic rd, wr;
  logic [WORD_W-1:0] clkdiv_q, enable_q, pending_q, start_q, rd_word;
  logic [BYTE_W-1:0] rbyte;
  logic cmd_busy, tx_busy, rx_full;

  assign widx      = bus_addr_i[ADDR_W-1:2];
  assign mapped    = (widx < WIDX_W'(NUM_REGS)) && (bus_addr_i[1:0] == 2'b00);
  assign sel_clk   = mapped && widx == WIDX_W'(OFF_CLKDIV);
  assign sel_en    = mapped && widx == WIDX_W'(OFF_ENABLE);
  assign sel_pend  = mapped && widx == WIDX_W'(OFF_PENDING);
  assign sel_start = mapped && widx == WIDX_W'(OFF_START);
  assign sel_cmd   = mapped && widx == WIDX_W'(OFF_CMD);
  assign sel_dat   = mapped && widx == WIDX_W'(OFF_DAT);
  assign wr        = bus_req_i && bus_we_i;
  assign rd        = bus_req_i && !bus_we_i;

  assign bus_unmap_o = bus_req_i && !mapped;

  always_comb begin
    bus_ack_o = bus_req_i;
    if (sel_cmd && card_present_i && cmd_busy) bus_ack_o = 1'b0;
    if (sel_dat && card_present_i && (bus_we_i ? tx_busy : !rx_full)) bus_ack_o = 1'b0;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel_clk)   bus_rdata_o = clkdiv_q;
    if (sel_en)    bus_rdata_o = enable_q;
    if (sel_pend)  bus_rdata_o = pending_q;
    if (sel_start) bus_rdata_o = start_q;
    if (sel_cmd)   bus_rdata_o = card_present_i ? {24'd0, rbyte} : 32'h0000_00FF;
    if (sel_dat)   bus_rdata_o = card_present_i ? rd_word : 32'hFFFF_FFFF;
  end

  assign clkdiv_o = clkdiv_q;
  assign enable_o = enable_q[3:0];
  assign start_o  = start_q[1:0];

  sdb_regs u_regs (
    .clk_i, .rst_ni,
    .wr_clkdiv_i (wr && sel_clk),
    .wr_enable_i (wr && sel_en),
    .wr_pending_i(wr && sel_pend),
    .wr_start_i  (wr && sel_start),
    .wdata_i     (bus_wdata_i),
    .clkdiv_o    (clkdiv_q),
    .enable_o    (enable_q),
    .pending_o   (pending_q),
    .start_o     (start_q)
  );

  sdb_cmd u_cmd (
    .clk_i, .rst_ni,
    .wr_i       (wr && sel_cmd && card_present_i && !cmd_busy),
    .rd_i       (rd && sel_cmd && card_present_i && !cmd_busy),
    .wbyte_i    (bus_wdata_i[7:0]),
    .busy_o     (cmd_busy),
    .rbyte_o    (rbyte),
    .wrap_o     (rsp_wrap_o),
    .cmd_valid_o, .cmd_ready_i, .cmd_index_o, .cmd_arg_o, .cmd_crc_o,
    .rsp_len_i, .rsp_data_i
  );

  sdb_dat u_dat (
    .clk_i, .rst_ni,
    .wr_i      (wr && sel_dat && card_present_i && !tx_busy),
    .wdata_i   (bus_wdata_i),
    .rd_req_i  (rd && sel_dat && card_present_i),
    .tx_busy_o (tx_busy),
    .rx_full_o (rx_full),
    .rd_word_o (rd_word),
    .dat_tx_valid_o, .dat_tx_ready_i, .dat_tx_byte_o,
    .dat_rx_valid_i, .dat_rx_ready_o, .dat_rx_byte_i
  );

  p_absent_cmd_rd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && sel_cmd && !card_present_i |-> bus_ack_o && bus_rdata_o == 32'h0000_00FF);
  p_absent_no_issue_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !card_present_i && !cmd_valid_o |=> !cmd_valid_o);
  p_unmap_ack_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_unmap_o |-> bus_ack_o && (bus_we_i || bus_rdata_o == '0));
  p_stall_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && sel_cmd && card_present_i && cmd_valid_o |-> !bus_ack_o);
endmodule

// File: tb/sim_sd_cmd_bridge.sv
module sim_sd_cmd_bridge;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ack, bus_unmap, rsp_wrap;
  logic card_present = 1;
  logic [31:0] clkdiv;
  logic [3:0] enable;
  logic [1:0] start;
  logic cmd_valid, cmd_ready = 0;
  logic [5:0] cmd_index;
  logic [31:0] cmd_arg;
  logic [7:0] cmd_crc;
  logic [4:0] rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic dat_tx_valid, dat_tx_ready = 1;
  logic [7:0] dat_tx_byte;
  logic dat_rx_valid, dat_rx_ready;
  logic [7:0] dat_rx_byte;

  always #(PER/2) clk = ~clk;

  sd_cmd_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_ack_o(bus_ack), .bus_unmap_o(bus_unmap), .rsp_wrap_o(rsp_wrap),
    .card_present_i(card_present), .clkdiv_o(clkdiv), .enable_o(enable),
    .start_o(start), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_index_o(cmd_index), .cmd_arg_o(cmd_arg), .cmd_crc_o(cmd_crc),
    .rsp_len_i(rsp_len), .rsp_data_i(rsp_data), .dat_tx_valid_o(dat_tx_valid),
    .dat_tx_ready_i(dat_tx_ready), .dat_tx_byte_o(dat_tx_byte),
    .dat_rx_valid_i(dat_rx_valid), .dat_rx_ready_o(dat_rx_ready),
    .dat_rx_byte_i(dat_rx_byte)
  );

  int n_chk = 0, n_fail = 0;
  logic last_unmap, last_wrap;
  int last_wait;
  bit done = 0;

  // card command model: answers 3 cycles after valid
  int issues = 0;
  logic [5:0] got_idx;
  logic [31:0] got_arg;
  logic [7:0] got_crc;
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      cmd_ready = 0;
      if (cmd_valid) begin
        dly++;
        if (dly == 3) begin
          cmd_ready = 1; dly = 0; issues++;
          got_idx = cmd_index; got_arg = cmd_arg; got_crc = cmd_crc;
        end
      end
    end
  end

  // transmit sink log
  logic [7:0] tx_log [16];
  int tx_n = 0;
  initial forever begin
    @(negedge clk);
    if (dat_tx_valid && dat_tx_ready && tx_n < 16) begin
      tx_log[tx_n] = dat_tx_byte; tx_n++;
    end
  end

  // receive source
  logic [7:0] rx_mem [4];
  int rx_idx = 4;
  assign dat_rx_valid = rx_idx < 4;
  assign dat_rx_byte  = dat_rx_valid ? rx_mem[rx_idx] : 8'h00;
  always @(posedge clk) if (dat_rx_ready && dat_rx_valid) rx_idx <= rx_idx + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    last_wait = 0;
    #1;
    while (!bus_ack && last_wait < 1000) begin
      @(negedge clk); #1; last_wait++;
    end
    r = bus_rdata; last_unmap = bus_unmap; last_wrap = rsp_wrap;
    @(posedge clk);
    #1 bus_req = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] r;
    access(1, a, d, r);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] r);
    access(0, a, 32'h0, r);
  endtask

  task automatic send_cmd(input logic [7:0] b0, input logic [31:0] arg, input logic [7:0] crc);
    wr(5'h10, {24'd0, b0});
    for (int i = 3; i >= 0; i--) wr(5'h10, {24'd0, arg[i*8 +: 8]});
    wr(5'h10, {24'd0, crc});
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd(5'h00, r); chk("R1 clkdiv", r, 0);
    rd(5'h04, r); chk("R1 enable", r, 0);
    rd(5'h08, r); chk("R1 pending", r, 0);
    rd(5'h0C, r); chk("R1 start", r, 0);
    rd(5'h10, r); chk("R1 rsp byte", r, 0); chk("R1 wrap on empty", last_wrap, 1);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    wr(5'h00, 32'hA5A5_1234); rd(5'h00, r); chk("R2 clkdiv", r, 32'hA5A5_1234);
    chk("R2 clkdiv_o", clkdiv, 32'hA5A5_1234);
    wr(5'h0C, 32'h8000_0003); rd(5'h0C, r); chk("R2 start", r, 32'h8000_0003);
    chk("R2 start_o", start, 2'b11);
  endtask

  task automatic t_pending();
    logic [31:0] r;
    wr(5'h04, 32'h0000_000F); rd(5'h08, r); chk("R3 pend from en", r, 32'hA);
    chk("R2 enable_o", enable, 4'hF);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, r); chk("R3 pend no clear", r, 32'hA);
    wr(5'h04, 32'h0000_0002); rd(5'h08, r); chk("R3 pend bit1 only", r, 32'h2);
  endtask

  task automatic t_cmd16();
    logic [31:0] r;
    rsp_len = 16;
    for (int k = 0; k < 16; k++) rsp_data[(15-k)*8 +: 8] = 8'h10 + 8'(k);
    send_cmd(8'h42, 32'h1234_5678, 8'h9B);
    rd(5'h10, r);
    chk("R9 stall while busy", 32'(last_wait > 0), 1);
    chk("R4 index", {26'd0, got_idx}, 32'h02);
    chk("R4 arg", got_arg, 32'h1234_5678);
    chk("R4 crc", {24'd0, got_crc}, 32'h9B);
    chk("R5 tag byte", r, 32'h3F);
    for (int k = 0; k < 16; k++) begin
      rd(5'h10, r); chk("R5 long byte", r, 32'h10 + k);
      chk("R7 no early wrap", last_wrap, 0);
    end
    rd(5'h10, r); chk("R7 wrap past 17", last_wrap, 1);
    rd(5'h10, r); chk("R7 restart at 0", r, 32'h3F);
  endtask

  task automatic t_cmd4();
    logic [31:0] r;
    rsp_len = 4;
    for (int k = 0; k < 16; k++) rsp_data[(15-k)*8 +: 8] = 8'hA0 + 8'(k);
    send_cmd(8'h57, 32'h0, 8'h01);
    rd(5'h10, r); chk("R6 index byte", r, 32'h17);
    for (int k = 0; k < 4; k++) begin rd(5'h10, r); chk("R6 short byte", r, 32'hA0 + k); end
    rd(5'h10, r); chk("R6 pad zero", r, 0); chk("R7 no wrap at 5", last_wrap, 0);
    rd(5'h10, r); chk("R7 wrap past 6", last_wrap, 1);
    rd(5'h10, r); chk("R7 back to index", r, 32'h17);
  endtask

  task automatic t_drop();
    logic [31:0] r;
    int base;
    rsp_len = 0;
    send_cmd(8'h40, 32'h0, 8'h95);
    rd(5'h10, r);
    base = issues;
    wr(5'h10, 32'hFF);
    send_cmd(8'h45, 32'h0102_0304, 8'h77);
    rd(5'h10, r);
    chk("R8 one issue", issues - base, 1);
    chk("R8 index after drop", {26'd0, got_idx}, 32'h05);
    chk("R8 arg after drop", got_arg, 32'h0102_0304);
    chk("R8 crc after drop", {24'd0, got_crc}, 32'h77);
  endtask

  task automatic t_dat_wr();
    tx_n = 0;
    wr(5'h14, 32'hDEAD_BEEF);
    repeat (8) @(negedge clk);
    chk("R10 byte count", tx_n, 4);
    chk("R10 byte0", tx_log[0], 8'hDE); chk("R10 byte1", tx_log[1], 8'hAD);
    chk("R10 byte2", tx_log[2], 8'hBE); chk("R10 byte3", tx_log[3], 8'hEF);
  endtask

  task automatic t_dat_rd();
    logic [31:0] r;
    rx_mem[0] = 8'h11; rx_mem[1] = 8'h22; rx_mem[2] = 8'h33; rx_mem[3] = 8'h44;
    @(negedge clk); rx_idx = 0;
    rd(5'h14, r);
    chk("R11 word", r, 32'h1122_3344);
    chk("R11 waited", 32'(last_wait >= 3), 1);
  endtask

  task automatic t_absent();
    logic [31:0] r;
    int base;
    card_present = 0;
    base = issues; tx_n = 0;
    for (int i = 0; i < 6; i++) wr(5'h10, 32'h4A);
    wr(5'h14, 32'h1234_5678);
    repeat (8) @(negedge clk);
    chk("R12 no issue", issues - base, 0);
    chk("R12 no tx", tx_n, 0);
    rd(5'h10, r); chk("R12 cmd read", r, 32'hFF);
    rd(5'h14, r); chk("R12 dat read", r, 32'hFFFF_FFFF);
    card_present = 1;
    send_cmd(8'h48, 32'hCAFE_0001, 8'h33);
    rd(5'h10, r);
    chk("R12 ptr untouched", {26'd0, got_idx}, 32'h08);
    chk("R12 arg after absent", got_arg, 32'hCAFE_0001);
  endtask

  task automatic t_unmap();
    logic [31:0] r;
    wr(5'h18, 32'h1234); chk("R13 wr strobe", last_unmap, 1);
    rd(5'h18, r); chk("R13 rd zero", r, 0); chk("R13 rd strobe", last_unmap, 1);
    rd(5'h1C, r); chk("R13 rd zero 7", r, 0);
    wr(5'h01, 32'h5555_5555); chk("R13 misaligned strobe", last_unmap, 1);
    rd(5'h00, r); chk("R13 clkdiv intact", r, 32'hA5A5_1234);
    chk("R13 mapped no strobe", last_unmap, 0);
  endtask

  initial begin
    #(PER*100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_pending();
    t_cmd16();
    t_cmd4();
    t_drop();
    t_dat_wr();
    t_dat_rd();
    t_absent();
    t_unmap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule